// File: doc/BRIEF.md
# DMA Event Interrupt Aggregator

This block gathers single-cycle event pulses from a multi-channel 2D DMA engine and turns them into two level-sensitive interrupt request lines. The events are a bus-error pulse and, for each of eight channels, one pulse when a 2D block finishes and one when a full frame finishes. Every event is latched into a 32-bit event word. Each interrupt line keeps its own copy of that word, and software reaches that copy through four registers: raw status, masked status, enable-set and enable-clear.

Software acknowledges an event by writing a one to the matching bit of a line's masked status register. This clears the latched bit even when the event is not enabled on that line. Writing a one to the raw status register sets the bit instead, so software can fire an interrupt on purpose. The two lines share the event sources but mask and acknowledge events on their own, so each can be routed to a different consumer.

Top module: `dma_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, every raw status bit and every enable bit is 0, both irq_o bits are 0, and every register reads 0.
- R2: An event pulse sets a bit in the raw status of both lines on the next clock edge. The bus error goes to bit 0, the block-done of channel c goes to bit 16+c, and the frame-done of channel c goes to bit 24+c. The bit stays set until it is cleared.
- R3: The masked status register (sel 1) reads as raw status AND enable mask.
- R4: irq_o[j] is 1 exactly when line j's masked status is nonzero. It follows the register state with no added delay.
- R5: Writing 1 to a bit of line j's masked status (sel 1) clears that raw bit in line j, whether or not the bit is enabled. Line j's masked view of the bit also drops to 0.
- R6: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R7: Writing 1s to enable-set (sel 2) sets enable bits, and writing 1s to enable-clear (sel 3) clears them. Reading either register returns the current enable mask.
- R8: Writing 1 to a bit of raw status (sel 0) sets that bit, which acts as a software-triggered event.
- R9: Bits 1 to 15 are reserved. They read as 0 in every register and ignore writes. Zero bits in any write change nothing.
- R10: The register address is {line, sel[1:0]}. A write to one line never changes the other line's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_err_i | input | 1 | Bus error event pulse |
| blk_done_i | input | 8 | Per-channel 2D block completion pulses |
| frm_done_i | input | 8 | Per-channel frame completion pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address {line, sel} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_o | output | 2 | Level interrupt outputs, one per line |

## Verification
Directed cases first send each event source on its own, so that a wrong bit position shows up. Next they clear a bit that is not enabled, which separates a clear that works only through the mask from one that works on raw status. A same-cycle event and clear shows whether set or clear wins. Writes to the reserved bits and all-zero writes test R9. Random cycles then mix sparse events with writes to random addresses on both lines. Every cycle is compared against a bench model of both lines, which catches any coupling between the lines and any wrong masking on irq_o.

// File: rtl/irq_agg_pkg.sv
// Package: shared widths and the event bit layout for the DMA interrupt aggregator.
// Assumes at most eight channels, so channel fields fit between bit 16 and bit 31.
package irq_agg_pkg;
    localparam int EV_W      = 32;
    localparam int BUS_BIT   = 0;
    localparam int BLK_BASE  = 16;
    localparam int FRM_BASE  = 24;
    localparam int SEL_RAW   = 0;
    localparam int SEL_STAT  = 1;
    localparam int SEL_ENSET = 2;
    localparam int SEL_ENCLR = 3;

    // Mask of implemented event bits for a given channel count.
    function automatic logic [EV_W-1:0] valid_mask(input int nch);
        logic [EV_W-1:0] m;
        m = '0;
        m[BUS_BIT] = 1'b1;
        for (int c = 0; c < nch; c++) begin
            m[BLK_BASE + c] = 1'b1;
            m[FRM_BASE + c] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irq_evt_map.sv
// Module: places the event pulses at their fixed positions in the event word.
// Assumes the pulses are synchronous to clk. Unused bits are tied to 0.
module irq_evt_map
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              bus_err_i,
    input  logic [NUM_CH-1:0] blk_done_i,
    input  logic [NUM_CH-1:0] frm_done_i,
    output logic [EV_W-1:0]   ev_o
);
    logic [EV_W-1:0] ev_w;

    // Build the event word from the individual pulses.
    always_comb begin
        ev_w = '0;
        ev_w[BUS_BIT] = bus_err_i;
        for (int c = 0; c < NUM_CH; c++) begin
            ev_w[BLK_BASE + c] = blk_done_i[c];
            ev_w[FRM_BASE + c] = frm_done_i[c];
        end
    end

    assign ev_o = ev_w;
endmodule

// File: rtl/irq_reg_decode.sv
// Module: decodes register writes into per-line set and clear strobes, and muxes the read data.
// Assumes the address is {line, sel[1:0]} and that writes take effect in a single cycle.
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int NUM_CH    = 8,
    parameter int ADDR_W    = $clog2(NUM_LINES) + 2
) (
    input  logic                            wr_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [EV_W-1:0]                 wdata_i,
    input  logic [NUM_LINES-1:0][EV_W-1:0]  raw_i,
    input  logic [NUM_LINES-1:0][EV_W-1:0]  en_i,
    output logic [NUM_LINES-1:0][EV_W-1:0]  raw_set_o,
    output logic [NUM_LINES-1:0][EV_W-1:0]  raw_clr_o,
    output logic [NUM_LINES-1:0][EV_W-1:0]  en_set_o,
    output logic [NUM_LINES-1:0][EV_W-1:0]  en_clr_o,
    output logic [EV_W-1:0]                 rdata_o
);
    localparam int LINE_W = ADDR_W - 2;
    localparam logic [EV_W-1:0] VALID = valid_mask(NUM_CH);

    logic [1:0]        sel;
    logic [LINE_W-1:0] line;
    logic [EV_W-1:0]   wbits;

    assign sel   = addr_i[1:0];
    assign line  = addr_i[ADDR_W-1:2];
    assign wbits = wdata_i & VALID;

    // Send the write to the addressed line's strobes only.
    always_comb begin
        raw_set_o = '0;
        raw_clr_o = '0;
        en_set_o  = '0;
        en_clr_o  = '0;
        for (int j = 0; j < NUM_LINES; j++) begin
            if (wr_i && (int'(line) == j)) begin
                case (sel)
                    2'(SEL_RAW):   raw_set_o[j] = wbits;
                    2'(SEL_STAT):  raw_clr_o[j] = wbits;
                    2'(SEL_ENSET): en_set_o[j]  = wbits;
                    default:       en_clr_o[j]  = wbits;
                endcase
            end
        end
    end

    // Select the read data for the addressed line and register.
    always_comb begin
        rdata_o = '0;
        for (int j = 0; j < NUM_LINES; j++) begin
            if (int'(line) == j) begin
                case (sel)
                    2'(SEL_RAW):  rdata_o = raw_i[j] & VALID;
                    2'(SEL_STAT): rdata_o = raw_i[j] & en_i[j] & VALID;
                    default:      rdata_o = en_i[j] & VALID;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_line_ctrl.sv
// Module: raw status and enable state for one interrupt line, and its level request.
// Assumes strobes come already masked to implemented bits. An event beats a clear on the same bit.
module irq_line_ctrl
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev_i,
    input  logic [EV_W-1:0] raw_set_i,
    input  logic [EV_W-1:0] raw_clr_i,
    input  logic [EV_W-1:0] en_set_i,
    input  logic [EV_W-1:0] en_clr_i,
    output logic [EV_W-1:0] raw_o,
    output logic [EV_W-1:0] en_o,
    output logic            irq_o
);
    localparam logic [EV_W-1:0] VALID = valid_mask(NUM_CH);

    logic [EV_W-1:0] raw_q, en_q;

    // Latch events and software sets, and drop acknowledged bits.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= ((raw_q & ~raw_clr_i) | raw_set_i | ev_i) & VALID;
    end

    // Update the enable mask from the set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= ((en_q | en_set_i) & ~en_clr_i) & VALID;
    end

    assign raw_o = raw_q;
    assign en_o  = en_q;
    assign irq_o = |(raw_q & en_q);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q | en_q) & ~VALID) == '0); // R9
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_i & VALID) != '0) |=> ((raw_q & $past(ev_i & VALID)) == $past(ev_i & VALID))); // R6
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_clr_i & ~ev_i & ~raw_set_i) != '0) |=> ((raw_q & $past(raw_clr_i & ~ev_i & ~raw_set_i)) == '0)); // R5
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_i == '0 && en_clr_i == '0) |=> $stable(en_q)); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((ev_i | raw_set_i | en_set_i) != '0)); // R4
endmodule

// File: rtl/dma_irq_agg.sv
// Module: top of the DMA interrupt aggregator. One event word feeds NUM_LINES separately masked lines.
// Assumes a synchronous active-low reset and single-cycle event pulses. Reads are combinational.
module dma_irq_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int NUM_CH    = 8,
    parameter int ADDR_W    = $clog2(NUM_LINES) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_err_i,
    input  logic [NUM_CH-1:0]    blk_done_i,
    input  logic [NUM_CH-1:0]    frm_done_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [EV_W-1:0]      reg_wdata_i,
    output logic [EV_W-1:0]      reg_rdata_o,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [EV_W-1:0]                ev;
    logic [NUM_LINES-1:0][EV_W-1:0] raw, en, raw_set, raw_clr, en_set, en_clr;

    irq_evt_map #(.NUM_CH(NUM_CH)) u_map (
        .bus_err_i (bus_err_i),
        .blk_done_i(blk_done_i),
        .frm_done_i(frm_done_i),
        .ev_o      (ev)
    );

    irq_reg_decode #(.NUM_LINES(NUM_LINES), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .raw_i    (raw),
        .en_i     (en),
        .raw_set_o(raw_set),
        .raw_clr_o(raw_clr),
        .en_set_o (en_set),
        .en_clr_o (en_clr),
        .rdata_o  (reg_rdata_o)
    );

    for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
        irq_line_ctrl #(.NUM_CH(NUM_CH)) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_i     (ev),
            .raw_set_i(raw_set[j]),
            .raw_clr_i(raw_clr[j]),
            .en_set_i (en_set[j]),
            .en_clr_i (en_clr[j]),
            .raw_o    (raw[j]),
            .en_o     (en[j]),
            .irq_o    (irq_o[j])
        );
    end

    AST_IDLE_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |-> (raw_set == '0 && raw_clr == '0 && en_set == '0 && en_clr == '0)); // R10
endmodule

// File: tb/dma_irq_agg_test.sv
module dma_irq_agg_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_err_i = 0;
    logic [7:0]  blk_done_i = 0, frm_done_i = 0;
    logic        reg_wr_i = 0;
    logic [2:0]  reg_addr_i = 0;
    logic [31:0] reg_wdata_i = 0;
    logic [31:0] reg_rdata_o;
    logic [1:0]  irq_o;

    int checks = 0, failures = 0;
    logic [31:0] m_raw [2];
    logic [31:0] m_en  [2];
    localparam logic [31:0] VAL = 32'hFFFF_0001;

    dma_irq_agg uut (.*);

    always #4 clk = ~clk;

    initial begin
        #1_000_000;
        failures++; checks++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic logic [31:0] ev_word(logic b, logic [7:0] bl, logic [7:0] fr);
        logic [31:0] e = 0;
        e[0] = b;
        for (int c = 0; c < 8; c++) begin e[16+c] = bl[c]; e[24+c] = fr[c]; end
        return e;
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] a);
        int l = a[2];
        case (a[1:0])
            2'd0: return m_raw[l];
            2'd1: return m_raw[l] & m_en[l];
            default: return m_en[l];
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply current inputs for one edge, updating the model, then idle inputs.
    task automatic tick();
        logic [31:0] e = ev_word(bus_err_i, blk_done_i, frm_done_i);
        logic [31:0] w = reg_wdata_i & VAL;
        int l = reg_addr_i[2];
        logic [31:0] nr[2], ne[2];
        for (int k = 0; k < 2; k++) begin nr[k] = m_raw[k]; ne[k] = m_en[k]; end
        if (reg_wr_i) case (reg_addr_i[1:0])
            2'd0: nr[l] = nr[l] | w;
            2'd1: nr[l] = nr[l] & ~w;
            2'd2: ne[l] = ne[l] | w;
            default: ne[l] = ne[l] & ~w;
        endcase
        for (int k = 0; k < 2; k++) begin m_raw[k] = nr[k] | e; m_en[k] = ne[k]; end
        @(posedge clk); #2;
        bus_err_i = 0; blk_done_i = 0; frm_done_i = 0; reg_wr_i = 0; reg_wdata_i = 0;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d; tick();
    endtask

    task automatic rd_check(string req, logic [2:0] a);
        reg_addr_i = a; #1;
        check(req, reg_rdata_o, exp_read(a));
    endtask

    task automatic irq_check(string req);
        check(req, {30'd0, irq_o},
              {30'd0, |(m_raw[1] & m_en[1]), |(m_raw[0] & m_en[0])});
    endtask

    initial begin
        m_raw[0] = 0; m_raw[1] = 0; m_en[0] = 0; m_en[1] = 0;
        bus_err_i = 1; reg_wr_i = 1; reg_wdata_i = '1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1; bus_err_i = 0; reg_wr_i = 0; reg_wdata_i = 0;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd_check("R1", 3'(a));
        irq_check("R1");

        // R2 mapping of each source, checked on both lines
        bus_err_i = 1; tick(); rd_check("R2 bus", 3'd0); rd_check("R2 bus", 3'd4);
        blk_done_i = 8'h01; tick(); rd_check("R2 blk0", 3'd0);
        blk_done_i = 8'h80; tick(); rd_check("R2 blk7", 3'd4);
        frm_done_i = 8'h04; tick(); rd_check("R2 frm2", 3'd0);
        check("R2 frm2 pos", reg_rdata_o & 32'h0400_0000, 32'h0400_0000);
        irq_check("R4 none enabled");

        // R5 clear without enable, line 1 untouched (R10)
        wr(3'd1, 32'h0000_0001); rd_check("R5", 3'd0); rd_check("R10", 3'd4);
        check("R5 bit0", reg_rdata_o & 1, 32'd1);

        // R7 enables, R3 masked view, R4 irq
        wr(3'd2, 32'h0400_0000); rd_check("R7 set", 3'd2); rd_check("R7 clr rd", 3'd3);
        rd_check("R3", 3'd1); irq_check("R4 line0");
        check("R4 line0 high", {31'd0, irq_o[0]}, 32'd1);
        wr(3'd3, 32'h0400_0000); rd_check("R7 clr", 3'd2); irq_check("R4 drop");

        // R6 same-cycle event and clear
        wr(3'd2, 32'h0001_0000);
        blk_done_i = 8'h01; reg_wr_i = 1; reg_addr_i = 3'd1; reg_wdata_i = 32'h0001_0000; tick();
        rd_check("R6", 3'd0);
        check("R6 bit16", reg_rdata_o & 32'h0001_0000, 32'h0001_0000);
        irq_check("R6 irq");

        // R8 software trigger on line 1
        wr(3'd6, 32'h0000_0001); wr(3'd4, 32'h0000_0001);
        rd_check("R8", 3'd5); irq_check("R8 irq");

        // R9 reserved bits and zero writes
        wr(3'd0, 32'h0000_FFFE); rd_check("R9 raw", 3'd0);
        wr(3'd2, 32'h0000_FFFE); rd_check("R9 en", 3'd2);
        check("R9 resv", reg_rdata_o & 32'h0000_FFFE, 0);
        wr(3'd1, 32'h0); rd_check("R9 zero", 3'd0);
        wr(3'd3, 32'h0); rd_check("R9 zero en", 3'd2);

        // Random mix, R10 coupling and R4 masking
        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(7) == 0) bus_err_i = 1;
            if ($urandom_range(3) == 0) blk_done_i = 8'(1 << $urandom_range(7));
            if ($urandom_range(3) == 0) frm_done_i = 8'(1 << $urandom_range(7));
            if ($urandom_range(1) == 0) begin
                reg_wr_i = 1; reg_addr_i = 3'($urandom_range(7)); reg_wdata_i = $urandom();
            end
            tick();
            irq_check("R4 random");
            rd_check("R10 random", 3'($urandom_range(7)));
        end
        for (int a = 0; a < 8; a++) rd_check("R3 final", 3'(a));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule